// File: doc/BRIEF.md
# Framebuffer Display Controller Register and Frame-Event Unit

This block is the software-visible control and status front end of a simple framebuffer display controller. A 32-bit register bus reaches a 16 KiB window of word registers on a 16-byte stride. These registers hold the run bit and pixel word-length, the frame geometry, and the current and queued buffer base addresses. The two control registers also take set, clear and toggle writes, so that software can change single bits without a read-modify-write.

The block raises a frame-done event in two ways. An internal frame-period counter, measured in clock cycles, fires one frame after scanout starts or after software acknowledges the previous event. Queueing a buffer also raises the event, at once. The event is a sticky flag in the second control register. The flag, gated by its enable bit, drives one level interrupt output. Only software clears the flag. Pixel fetch and display timing other than the frame tick belong to other blocks.

Top module: `fbc_regs_top`

## Requirements
- R1: After reset the control register (offset 0x000) reads 0, the second control register (offset 0x010) reads 0x000F0000, every other register reads 0, and the interrupt is low.
- R2: Address bits [3:2] select the write operation: 0 stores the data, 1 ORs it in, 2 clears the bits that are set in the data, and 3 XORs it in. Plain writes store all 32 bits of the control register (bit 0 is the run bit, bits [9:8] the pixel word length), the second control register, the geometry register at 0x030 (width in [15:0], height in [31:16]) and the current-buffer register at 0x040.
- R3: Set, clear and toggle writes work on the control register at 0x000 and the second control register at 0x010, at offsets +0x4, +0x8 and +0xC.
- R4: A set, clear or toggle write to any other register changes nothing. A write at an offset above 0x23C, or to an in-range offset with no register, is ignored and reads back 0.
- R5: The interrupt output is the frame-done flag (bit 9 of 0x010) ANDed with its enable (bit 13 of 0x010). It follows every register update.
- R6: A plain write to the queued-buffer register at 0x050 stores the value there, copies it into the current-buffer register at 0x040, and sets the frame-done flag on the same clock edge.
- R7: A plain write to the alternate queued-buffer register at 0x230 stores the value and sets the frame-done flag. It leaves the current-buffer register unchanged.
- R8: When the run bit goes from 0 to 1 with no frame-done pending, the frame-done flag sets on the (FRAME_CYCLES+1)-th clock edge after the write edge, and not before.
- R9: A software write that takes the frame-done flag from 1 to 0 while the run bit is set restarts the frame period. The flag sets again FRAME_CYCLES+1 edges after that write. A run bit set while the flag is pending does not fire before the flag is cleared.
- R10: Clearing the run bit cancels the frame period, and no frame-done follows. A later 0-to-1 change of the run bit starts a full new period.
- R11: A read strobe loads the addressed register into the read-data output on that clock edge. The value holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 14 | Byte address within the register window, word aligned |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per access |
| busRe | input | 1 | Read strobe, one cycle per access |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Level interrupt: frame-done and its enable |

## Verification
The embedded assertions check on every cycle the following:
- a queued-buffer write copies into the current buffer and sets frame-done;
- an alternate queued-buffer write leaves the current buffer alone;
- a falling run bit stops the frame counter;
- the interrupt rises only after a register update or a frame tick;
- writes outside the window leave run and frame-done untouched.

Some properties need scenarios. The exact number of cycles from the run bit rising, or from the flag being acknowledged, to frame-done is one. Another is the bit arithmetic of each set, clear and toggle write on both control registers. The third is that aliases to other registers are ignored. The bench sweeps all four operations over several patterns and counts edges against the frame period.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 4;

  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CTRL1 = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_GEOM  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_CUR   = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_NEXT  = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_ALT   = IDX_W'(35);

  localparam int RUN_BIT  = 0;
  localparam int DONE_BIT = 9;
  localparam int IEN_BIT  = 13;
  localparam logic [DATA_W-1:0] CTRL1_RST = 32'h000F_0000;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } wrOp_e;

  typedef enum logic [2:0] {
    RD_CTRL, RD_CTRL1, RD_GEOM, RD_CUR, RD_NEXT, RD_ALT, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrCtrl1;
    logic              wrGeom;
    logic              wrCur;
    logic              wrNext;
    logic              wrAlt;
    wrOp_e             op;
    logic [DATA_W-1:0] data;
    logic              frameTick;
    logic              rdEn;
    rdSel_e            rdSel;
  } regStrobe_t;
endpackage

// File: rtl/fbc_ctl.sv
module fbc_ctl
  import fbc_pkg::*;
#(
  parameter int FRAME_CYCLES = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              run,
  input  logic              done,
  output regStrobe_t        st
);
  localparam int CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [IDX_W-1:0] idx;
  wrOp_e            op;
  logic             plainOp;
  logic             runPrev, donePrev;
  logic             timerActive;
  logic [CNT_W-1:0] timerCnt;
  logic             runRise, runFall, doneFall, restart;

  assign idx     = busAddr[ADDR_W-1:4];
  assign op      = wrOp_e'(busAddr[3:2]);
  assign plainOp = (op == OP_WRITE);

  assign runRise  = run && !runPrev;
  assign runFall  = !run && runPrev;
  assign doneFall = !done && donePrev;
  assign restart  = (runRise || doneFall) && run && !done;

  always_comb begin
    st         = '0;
    st.op      = op;
    st.data    = busWdata;
    st.wrCtrl  = busWe && (idx == IDX_CTRL);
    st.wrCtrl1 = busWe && (idx == IDX_CTRL1);
    st.wrGeom  = busWe && plainOp && (idx == IDX_GEOM);
    st.wrCur   = busWe && plainOp && (idx == IDX_CUR);
    st.wrNext  = busWe && plainOp && (idx == IDX_NEXT);
    st.wrAlt   = busWe && plainOp && (idx == IDX_ALT);
    st.frameTick = timerActive && (timerCnt == CNT_LAST) && run && !done && !restart;
    st.rdEn    = busRe;
    case (idx)
      IDX_CTRL:  st.rdSel = RD_CTRL;
      IDX_CTRL1: st.rdSel = RD_CTRL1;
      IDX_GEOM:  st.rdSel = RD_GEOM;
      IDX_CUR:   st.rdSel = RD_CUR;
      IDX_NEXT:  st.rdSel = RD_NEXT;
      IDX_ALT:   st.rdSel = RD_ALT;
      default:   st.rdSel = RD_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runPrev     <= 1'b0;
      donePrev    <= 1'b0;
      timerActive <= 1'b0;
      timerCnt    <= '0;
    end else begin
      runPrev  <= run;
      donePrev <= done;
      if (runFall) begin
        timerActive <= 1'b0;
      end else if (restart) begin
        timerActive <= 1'b1;
        timerCnt    <= '0;
      end else if (timerActive) begin
        if (timerCnt == CNT_LAST) timerActive <= 1'b0;
        else                      timerCnt    <= timerCnt + 1'b1;
      end
    end
  end

  // R10: a stopped controller leaves no frame period running
  a_r10_stop_cancels: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |=> !timerActive);
endmodule

// File: rtl/fbc_dp.sv
module fbc_dp
  import fbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        st,
  output logic [DATA_W-1:0] busRdata,
  output logic              run,
  output logic              done,
  output logic              irqOut
);
  logic [DATA_W-1:0] ctrlReg, ctrl1Reg, geomReg, curReg, nextReg, altReg;
  logic [DATA_W-1:0] ctrlNew, ctrl1New, rdMux;

  function automatic logic [DATA_W-1:0] applyOp(
    input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] d, input wrOp_e o);
    case (o)
      OP_SET:  return old | d;
      OP_CLR:  return old & ~d;
      OP_TOG:  return old ^ d;
      default: return d;
    endcase
  endfunction

  always_comb begin
    ctrlNew  = st.wrCtrl  ? applyOp(ctrlReg,  st.data, st.op) : ctrlReg;
    ctrl1New = st.wrCtrl1 ? applyOp(ctrl1Reg, st.data, st.op) : ctrl1Reg;
    if (st.wrNext || st.wrAlt || st.frameTick) ctrl1New[DONE_BIT] = 1'b1;
    case (st.rdSel)
      RD_CTRL:  rdMux = ctrlReg;
      RD_CTRL1: rdMux = ctrl1Reg;
      RD_GEOM:  rdMux = geomReg;
      RD_CUR:   rdMux = curReg;
      RD_NEXT:  rdMux = nextReg;
      RD_ALT:   rdMux = altReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      ctrl1Reg <= CTRL1_RST;
      geomReg  <= '0;
      curReg   <= '0;
      nextReg  <= '0;
      altReg   <= '0;
      busRdata <= '0;
    end else begin
      ctrlReg  <= ctrlNew;
      ctrl1Reg <= ctrl1New;
      if (st.wrGeom) geomReg <= st.data;
      if (st.wrCur)  curReg  <= st.data;
      if (st.wrNext) begin
        nextReg <= st.data;
        curReg  <= st.data;
      end
      if (st.wrAlt) altReg <= st.data;
      if (st.rdEn)  busRdata <= rdMux;
    end
  end

  assign run    = ctrlReg[RUN_BIT];
  assign done   = ctrl1Reg[DONE_BIT];
  assign irqOut = ctrl1Reg[DONE_BIT] & ctrl1Reg[IEN_BIT];

  // R6: queued buffer becomes current and frame-done is raised
  a_r6_next_copies: assert property (@(posedge clk) disable iff (!rstN)
    st.wrNext |=> (curReg == $past(st.data)) && done);
  // R7: alternate queue write leaves the current buffer alone
  a_r7_alt_keeps_cur: assert property (@(posedge clk) disable iff (!rstN)
    st.wrAlt |=> $stable(curReg) && done);
  // R5: interrupt rises only after an update of the flag register or a tick
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(st.wrCtrl1 || st.wrNext || st.wrAlt || st.frameTick));
endmodule

// File: rtl/fbc_regs_top.sv
module fbc_regs_top
  import fbc_pkg::*;
#(
  parameter int FRAME_CYCLES = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  regStrobe_t strobes;
  logic       runW, doneW;

  fbc_ctl #(.FRAME_CYCLES(FRAME_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .run(runW), .done(doneW), .st(strobes));

  fbc_dp u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .busRdata(busRdata),
    .run(runW), .done(doneW), .irqOut(irqOut));

  // R4: writes beyond the last register touch neither run nor frame-done
  a_r4_far_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr[ADDR_W-1:4] > IDX_ALT) && !strobes.frameTick)
      |=> $stable(runW) && $stable(doneW));
endmodule

// File: tb/tb_fbc_regs_top.sv
module tb_fbc_regs_top;
  localparam int F = 20;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;
  int total = 0, bad = 0;
  bit finished = 0;

  fbc_regs_top #(.FRAME_CYCLES(F)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1 busWe = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1;
    @(posedge clk); #1 busRe = 1'b0; d = busRdata;
  endtask

  function automatic logic [31:0] model(input logic [31:0] o, input logic [31:0] d, input int op);
    case (op)
      1: return o | d;
      2: return o & ~d;
      3: return o ^ d;
      default: return d;
    endcase
  endfunction

  function automatic logic irqOf(input logic [31:0] c1);
    return c1[9] & c1[13];
  endfunction

  initial begin
    logic [31:0] v, expC, expC1, held;
    logic [31:0] pats [4] = '{32'h0000_2200, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0F0F_0200};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(14'h000, v); chk("R1 ctrl reset", v, 32'h0);
    rd(14'h010, v); chk("R1 ctrl1 reset", v, 32'h000F_0000);
    rd(14'h030, v); chk("R1 geometry reset", v, 32'h0);
    rd(14'h040, v); chk("R1 cur reset", v, 32'h0);
    rd(14'h050, v); chk("R1 next reset", v, 32'h0);
    rd(14'h230, v); chk("R1 alt reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irqOut}, 32'h0);

    // R2 R3 R5 sweep of all ops over ctrl1 (run stays 0)
    expC1 = 32'h000F_0000;
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 4; p++) begin
        wr(14'h010 + 14'(op * 4), pats[p]);
        expC1 = model(expC1, pats[p], op);
        rd(14'h010, v); chk(op == 0 ? "R2 ctrl1 plain" : "R3 ctrl1 alias", v, expC1);
        chk("R5 irq level", {31'b0, irqOut}, {31'b0, irqOf(expC1)});
      end
    wr(14'h010, 32'h0);

    // R2 R3 sweep over ctrl with run bit kept clear
    expC = 32'h0;
    for (int op = 0; op < 4; op++)
      for (int p = 0; p < 4; p++) begin
        wr(14'h000 + 14'(op * 4), pats[p] & ~32'h1);
        expC = model(expC, pats[p] & ~32'h1, op);
        rd(14'h000, v); chk(op == 0 ? "R2 ctrl plain" : "R3 ctrl alias", v, expC);
      end
    wr(14'h000, 32'h0);

    // R2 geometry fields and current buffer
    wr(14'h030, {16'd480, 16'd800});
    rd(14'h030, v);
    chk("R2 geometry width", {16'b0, v[15:0]}, 32'd800);
    chk("R2 geometry height", {16'b0, v[31:16]}, 32'd480);
    wr(14'h040, 32'h8000_1000);
    rd(14'h040, v); chk("R2 cur plain", v, 32'h8000_1000);

    // R4 aliases on other registers and far/unused offsets
    wr(14'h034, 32'hFFFF_FFFF);
    rd(14'h030, v); chk("R4 geometry alias ignored", v, {16'd480, 16'd800});
    wr(14'h054, 32'hDEAD_0000);
    rd(14'h050, v); chk("R4 next alias ignored", v, 32'h0);
    rd(14'h040, v); chk("R4 next alias no copy", v, 32'h8000_1000);
    rd(14'h010, v); chk("R4 next alias no done", v, 32'h0);
    wr(14'h240, 32'h5555_5555);
    rd(14'h240, v); chk("R4 far offset reads zero", v, 32'h0);
    wr(14'h020, 32'h5555_5555);
    rd(14'h020, v); chk("R4 unused offset reads zero", v, 32'h0);
    wr(14'h3FF0, 32'h1);
    rd(14'h000, v); chk("R4 far write leaves ctrl", v, 32'h0);

    // R6 queued buffer
    wr(14'h010, 32'h0000_2000);
    wr(14'h050, 32'h9000_0000);
    chk("R6 irq after queue", {31'b0, irqOut}, 32'h1);
    rd(14'h040, v); chk("R6 cur copied", v, 32'h9000_0000);
    rd(14'h050, v); chk("R6 next stored", v, 32'h9000_0000);
    rd(14'h010, v); chk("R6 done set", v, 32'h0000_2200);

    // R7 alternate queued buffer
    wr(14'h018, 32'h0000_0200);
    chk("R7 done cleared", {31'b0, irqOut}, 32'h0);
    wr(14'h230, 32'hA000_0000);
    chk("R7 irq after alt", {31'b0, irqOut}, 32'h1);
    rd(14'h040, v); chk("R7 cur unchanged", v, 32'h9000_0000);
    rd(14'h230, v); chk("R7 alt stored", v, 32'hA000_0000);
    wr(14'h018, 32'h0000_0200);

    // R11 read data holds without a read strobe
    rd(14'h050, v);
    held = v;
    wr(14'h040, 32'h1);
    repeat (3) @(posedge clk);
    #1 chk("R11 read data held", busRdata, held);

    // R8 frame period from run rising
    wr(14'h004, 32'h1);
    repeat (F) @(posedge clk);
    #1 chk("R8 no done before period", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    #1 chk("R8 done after period", {31'b0, irqOut}, 32'h1);

    // R9 clearing the flag restarts the period
    wr(14'h018, 32'h0000_0200);
    repeat (F) @(posedge clk);
    #1 chk("R9 no done before restart period", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    #1 chk("R9 done after restart period", {31'b0, irqOut}, 32'h1);

    // R9 run set while flag pending: nothing until acknowledged
    wr(14'h000, 32'h0);
    wr(14'h000, 32'h1);
    repeat (3 * F) @(posedge clk);
    wr(14'h01C, 32'h0000_0200);
    repeat (F) @(posedge clk);
    #1 chk("R9 pending blocked then restarted", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    #1 chk("R9 done after ack with run", {31'b0, irqOut}, 32'h1);
    wr(14'h018, 32'h0000_0200);

    // R10 stop cancels, restart runs a full period
    repeat (F / 2) @(posedge clk);
    wr(14'h008, 32'h1);
    repeat (3 * F) @(posedge clk);
    #1 chk("R10 no done after stop", {31'b0, irqOut}, 32'h0);
    wr(14'h000, 32'h1);
    repeat (F) @(posedge clk);
    #1 chk("R10 full period after restart", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    #1 chk("R10 done after new period", {31'b0, irqOut}, 32'h1);
    rd(14'h010, v); chk("R10 flag via bus", v, 32'h0000_2200);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule